// File: doc/BRIEF.md
# Vector Step Control Unit

This block carries out one vector step-control operation at a time against a small vector-state register. The state holds a source element step and a destination element step, a source and a destination sub-element step, and two loop-order flags (pack and unpack). A 4-bit selector chooses the operation. It can read back one state field, read the current offset of one of four externally computed shapes, write the pack/unpack flags, or ask for an explicit advance to the next element. A separate step-enable bit decides whether the state may change at all.

The element iterator that works out the next step values lives outside the block. The block presents its current state on plain output pins. When an advance is taken, it pulses a request and loads the iterator's next-state inputs in the same cycle. Each operation yields a 64-bit result. When the record bit is set, it also yields a 4-bit condition field whose equal bit reports that the state sits on the last possible element.

Operations enter on a valid/ready channel and results leave on a second one. A result may be held back with `res_ready` low. While the result register is full and not being drained, `op_ready` is low and no new operation is taken. The upstream side must keep `op_valid` and its operation fields steady until `op_ready` is seen high. The vector length and sub-vector size are plain configuration pins.

Top module: `svs_step_unit`

## Requirements
- R1: After reset `res_valid` is 0, both step fields and both substep fields read 0, and the pack and unpack flags are 0.
- R2: An accepted operation with selector 12 to 15 and `op_step`=1 writes pack from selector bit 0 and unpack from selector bit 1: 12 clears both, 13 sets only pack, 14 sets only unpack, 15 sets both. The result is zero except bit 0 = new pack and bit 1 = new unpack.
- R3: Selector 12 to 15 with `op_step`=0 leaves both flags unchanged and returns the current flags in bits 0 (pack) and 1 (unpack), all other bits zero.
- R4: Selectors 1, 2, 3 and 4 return the offset of shape 0, 1, 2 and 3, zero-extended to 64 bits. Shape k occupies bits [k*SHP_W +: SHP_W] of `shape_off`.
- R5: Selectors 5, 6, 7 and 8 return the source step, destination step, source substep and destination substep, zero-extended to 64 bits.
- R6: Selector 0 with `op_step`=1 raises `adv_req` for exactly the acceptance cycle, loads the four `nxt_*` inputs into the state at that clock edge, and returns 0.
- R7: With `op_step`=0 no operation alters the state and `adv_req` stays low. Selector 0 with `op_step`=0 returns 0.
- R8: Selectors 9, 10 and 11 return 0 and change no state.
- R9: With `op_rec`=1, `res_cond` bit 1 is 1 exactly when, in the state after the operation, either (source step = `cfg_vl`-1 and source substep = `cfg_subvl`) or (destination step = `cfg_vl`-1 and destination substep = `cfg_subvl`). Bits 3, 2 and 0 are 0. With `op_rec`=0, `res_cond` is 0.
- R10: `op_ready` equals `!res_valid || res_ready`. While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_data` and `res_cond` hold their values.
- R11: An operation accepted at a clock edge shows its result with `res_valid`=1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be taken this cycle |
| op_sel | input | 4 | Operation selector |
| op_step | input | 1 | Step enable; 0 means inquiry only |
| op_rec | input | 1 | Record bit; produce condition field |
| shape_off | input | 4*SHP_W | Current offsets of shapes 0..3 |
| cfg_vl | input | STEP_W | Vector length (at least 1) |
| cfg_subvl | input | SUB_W | Last sub-element index (sub-vector size minus 1) |
| nxt_src | input | STEP_W | Iterator's next source step |
| nxt_dst | input | STEP_W | Iterator's next destination step |
| nxt_ssub | input | SUB_W | Iterator's next source substep |
| nxt_dsub | input | SUB_W | Iterator's next destination substep |
| adv_req | output | 1 | Advance taken this cycle |
| cur_src | output | STEP_W | Current source step |
| cur_dst | output | STEP_W | Current destination step |
| cur_ssub | output | SUB_W | Current source substep |
| cur_dsub | output | SUB_W | Current destination substep |
| cur_pack | output | 1 | Current pack flag |
| cur_unpack | output | 1 | Current unpack flag |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_data | output | 64 | Operation result |
| res_cond | output | 4 | Condition field, bit 1 = end of loop |

## Verification
The bench targets a mode write issued with step enable low. A design that ignores the gate would flip the flags there, and one that reports the selector bits rather than the kept flags would return the wrong value. It steers the iterator inputs onto the last element with the record bit set. A design that tests the end condition on the state from before the advance would report the equal bit one operation late. It holds `res_ready` low across new offers to catch a result register that is overwritten or an input that is taken while full. It also sweeps the reserved selectors and all four shape and step reads, which exposes off-by-one index decoding.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam int SEL_W  = 4;
  localparam int NSHAPE = 4;
  localparam int SIDX_W = $clog2(NSHAPE);
  localparam int COND_W = 4;
  localparam int EQ_BIT = 1;

  typedef enum logic [2:0] {
    K_ADV   = 3'd0,
    K_SHAPE = 3'd1,
    K_FIELD = 3'd2,
    K_RSV   = 3'd3,
    K_FLAGS = 3'd4
  } op_kind_e;

  function automatic op_kind_e classify(input logic [SEL_W-1:0] s);
    if (s == '0)                      return K_ADV;
    else if (s <= SEL_W'(NSHAPE))     return K_SHAPE;
    else if (s <= SEL_W'(8))          return K_FIELD;
    else if (s[3:2] == 2'b11)         return K_FLAGS;
    else                              return K_RSV;
  endfunction
endpackage

// File: rtl/svs_decode.sv
module svs_decode
  import svs_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic              step,
  output op_kind_e          kind,
  output logic              do_adv,
  output logic              wr_flags,
  output logic [SIDX_W-1:0] shape_idx,
  output logic [1:0]        field_idx
);
  logic [SEL_W-1:0] sel_m1;

  always_comb begin
    kind      = classify(sel);
    do_adv    = (kind == K_ADV) && step;
    wr_flags  = (kind == K_FLAGS) && step;
    sel_m1    = sel - SEL_W'(1);
    shape_idx = sel_m1[SIDX_W-1:0];
    // 5->0 src, 6->1 dst, 7->2 ssub, 8->3 dsub
    field_idx = 2'(sel - SEL_W'(5));
  end

  always_comb begin
    if (kind == K_FLAGS) assert (sel[3:2] == 2'b11) else $error("p_flags_decode_r2");
    if (do_adv)          assert (sel == '0)         else $error("p_adv_decode_r6");
  end
endmodule

// File: rtl/svs_state.sv
module svs_state #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              do_adv,
  input  logic              wr_flags,
  input  logic              set_pack,
  input  logic              set_unpack,
  input  logic [STEP_W-1:0] nxt_src,
  input  logic [STEP_W-1:0] nxt_dst,
  input  logic [SUB_W-1:0]  nxt_ssub,
  input  logic [SUB_W-1:0]  nxt_dsub,
  output logic [STEP_W-1:0] cur_src,
  output logic [STEP_W-1:0] cur_dst,
  output logic [SUB_W-1:0]  cur_ssub,
  output logic [SUB_W-1:0]  cur_dsub,
  output logic              cur_pack,
  output logic              cur_unpack,
  output logic [STEP_W-1:0] nx_src,
  output logic [STEP_W-1:0] nx_dst,
  output logic [SUB_W-1:0]  nx_ssub,
  output logic [SUB_W-1:0]  nx_dsub,
  output logic              nx_pack,
  output logic              nx_unpack
);
  always_comb begin
    nx_src    = cur_src;
    nx_dst    = cur_dst;
    nx_ssub   = cur_ssub;
    nx_dsub   = cur_dsub;
    nx_pack   = cur_pack;
    nx_unpack = cur_unpack;
    if (acc && do_adv) begin
      nx_src  = nxt_src;
      nx_dst  = nxt_dst;
      nx_ssub = nxt_ssub;
      nx_dsub = nxt_dsub;
    end
    if (acc && wr_flags) begin
      nx_pack   = set_pack;
      nx_unpack = set_unpack;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_src    <= '0;
      cur_dst    <= '0;
      cur_ssub   <= '0;
      cur_dsub   <= '0;
      cur_pack   <= 1'b0;
      cur_unpack <= 1'b0;
    end else begin
      cur_src    <= nx_src;
      cur_dst    <= nx_dst;
      cur_ssub   <= nx_ssub;
      cur_dsub   <= nx_dsub;
      cur_pack   <= nx_pack;
      cur_unpack <= nx_unpack;
    end
  end

  p_adv_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && do_adv) |=> (cur_src == $past(nxt_src)) && (cur_dst == $past(nxt_dst))
                        && (cur_ssub == $past(nxt_ssub)) && (cur_dsub == $past(nxt_dsub)));

  p_flag_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_flags) |=> (cur_pack == $past(set_pack)) && (cur_unpack == $past(set_unpack)));

  p_steps_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_flags) |=> $stable(cur_src) && $stable(cur_dst));
endmodule

// File: rtl/svs_result.sv
module svs_result
  import svs_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int SHP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  output logic                     op_ready,
  input  logic                     op_rec,
  input  op_kind_e                 kind,
  input  logic [SIDX_W-1:0]        shape_idx,
  input  logic [1:0]               field_idx,
  input  logic [NSHAPE*SHP_W-1:0]  shape_off,
  input  logic [STEP_W-1:0]        cfg_vl,
  input  logic [SUB_W-1:0]         cfg_subvl,
  input  logic [STEP_W-1:0]        cur_src,
  input  logic [STEP_W-1:0]        cur_dst,
  input  logic [SUB_W-1:0]         cur_ssub,
  input  logic [SUB_W-1:0]         cur_dsub,
  input  logic [STEP_W-1:0]        nx_src,
  input  logic [STEP_W-1:0]        nx_dst,
  input  logic [SUB_W-1:0]         nx_ssub,
  input  logic [SUB_W-1:0]         nx_dsub,
  input  logic                     nx_pack,
  input  logic                     nx_unpack,
  output logic                     acc,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [XLEN-1:0]          res_data,
  output logic [COND_W-1:0]        res_cond
);
  logic [SHP_W-1:0]  shp [NSHAPE];
  logic [XLEN-1:0]   d_data;
  logic [COND_W-1:0] d_cond;
  logic [STEP_W-1:0] vl_last;
  logic              at_end;

  for (genvar g = 0; g < NSHAPE; g++) begin : g_shape
    assign shp[g] = shape_off[g*SHP_W +: SHP_W];
  end

  assign op_ready = !res_valid || res_ready;
  assign acc      = op_valid && op_ready;
  assign vl_last  = cfg_vl - STEP_W'(1);

  always_comb begin
    at_end = ((nx_src == vl_last) && (nx_ssub == cfg_subvl)) ||
             ((nx_dst == vl_last) && (nx_dsub == cfg_subvl));
    d_cond = '0;
    if (op_rec) d_cond[EQ_BIT] = at_end;
  end

  always_comb begin
    d_data = '0;
    unique case (kind)
      K_SHAPE: d_data = XLEN'(shp[shape_idx]);
      K_FIELD: begin
        unique case (field_idx)
          2'd0: d_data = XLEN'(cur_src);
          2'd1: d_data = XLEN'(cur_dst);
          2'd2: d_data = XLEN'(cur_ssub);
          default: d_data = XLEN'(cur_dsub);
        endcase
      end
      K_FLAGS: d_data = XLEN'({nx_unpack, nx_pack});
      default: d_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_cond  <= '0;
    end else if (acc) begin
      res_valid <= 1'b1;
      res_data  <= d_data;
      res_cond  <= d_cond;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data) && $stable(res_cond));

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);

  p_cond_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !op_rec) |=> (res_cond == '0));

  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (kind == K_RSV || kind == K_ADV)) |=> (res_data == '0));
endmodule

// File: rtl/svs_step_unit.sv
module svs_step_unit
  import svs_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int SHP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  output logic                    op_ready,
  input  logic [SEL_W-1:0]        op_sel,
  input  logic                    op_step,
  input  logic                    op_rec,
  input  logic [NSHAPE*SHP_W-1:0] shape_off,
  input  logic [STEP_W-1:0]       cfg_vl,
  input  logic [SUB_W-1:0]        cfg_subvl,
  input  logic [STEP_W-1:0]       nxt_src,
  input  logic [STEP_W-1:0]       nxt_dst,
  input  logic [SUB_W-1:0]        nxt_ssub,
  input  logic [SUB_W-1:0]        nxt_dsub,
  output logic                    adv_req,
  output logic [STEP_W-1:0]       cur_src,
  output logic [STEP_W-1:0]       cur_dst,
  output logic [SUB_W-1:0]        cur_ssub,
  output logic [SUB_W-1:0]        cur_dsub,
  output logic                    cur_pack,
  output logic                    cur_unpack,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [XLEN-1:0]         res_data,
  output logic [COND_W-1:0]       res_cond
);
  op_kind_e          kind;
  logic              do_adv, wr_flags, acc;
  logic [SIDX_W-1:0] shape_idx;
  logic [1:0]        field_idx;
  logic [STEP_W-1:0] nx_src, nx_dst;
  logic [SUB_W-1:0]  nx_ssub, nx_dsub;
  logic              nx_pack, nx_unpack;

  svs_decode u_dec (
    .sel(op_sel), .step(op_step), .kind(kind), .do_adv(do_adv),
    .wr_flags(wr_flags), .shape_idx(shape_idx), .field_idx(field_idx)
  );

  svs_state #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_state (
    .clk(clk), .rst_n(rst_n), .acc(acc), .do_adv(do_adv), .wr_flags(wr_flags),
    .set_pack(op_sel[0]), .set_unpack(op_sel[1]),
    .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_ssub(nxt_ssub), .nxt_dsub(nxt_dsub),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_ssub(cur_ssub), .cur_dsub(cur_dsub),
    .cur_pack(cur_pack), .cur_unpack(cur_unpack),
    .nx_src(nx_src), .nx_dst(nx_dst), .nx_ssub(nx_ssub), .nx_dsub(nx_dsub),
    .nx_pack(nx_pack), .nx_unpack(nx_unpack)
  );

  svs_result #(.XLEN(XLEN), .STEP_W(STEP_W), .SUB_W(SUB_W), .SHP_W(SHP_W)) u_res (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_rec(op_rec), .kind(kind), .shape_idx(shape_idx), .field_idx(field_idx),
    .shape_off(shape_off), .cfg_vl(cfg_vl), .cfg_subvl(cfg_subvl),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_ssub(cur_ssub), .cur_dsub(cur_dsub),
    .nx_src(nx_src), .nx_dst(nx_dst), .nx_ssub(nx_ssub), .nx_dsub(nx_dsub),
    .nx_pack(nx_pack), .nx_unpack(nx_unpack), .acc(acc),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_cond(res_cond)
  );

  assign adv_req = acc && do_adv;

  p_inquire_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_step) |=> $stable(cur_src) && $stable(cur_dst)
      && $stable(cur_ssub) && $stable(cur_dsub) && $stable(cur_pack) && $stable(cur_unpack));

  p_no_req_inquiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_step |-> !adv_req);

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_req |-> op_valid && op_ready);
endmodule

// File: tb/tb_svs_step_unit.sv
`timescale 1ns/1ps
module tb_svs_step_unit;
  localparam int SHP_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_step = 1'b0, op_rec = 1'b0, res_ready = 1'b1;
  logic [3:0] op_sel = '0;
  logic [4*SHP_W-1:0] shape_off = '0;
  logic [6:0] cfg_vl = 7'd4;
  logic [1:0] cfg_subvl = 2'd1;
  logic [6:0] nxt_src = '0, nxt_dst = '0;
  logic [1:0] nxt_ssub = '0, nxt_dsub = '0;
  logic op_ready, adv_req, cur_pack, cur_unpack, res_valid;
  logic [6:0] cur_src, cur_dst;
  logic [1:0] cur_ssub, cur_dsub;
  logic [63:0] res_data;
  logic [3:0] res_cond;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit rand_rdy = 0;

  // reference state
  logic [6:0] m_src = '0, m_dst = '0;
  logic [1:0] m_ssub = '0, m_dsub = '0;
  logic m_pack = 0, m_unpack = 0, m_ov = 0;
  logic [63:0] m_res = '0;
  logic [3:0] m_cond = '0;
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  svs_step_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .op_step(op_step), .op_rec(op_rec), .shape_off(shape_off),
    .cfg_vl(cfg_vl), .cfg_subvl(cfg_subvl), .nxt_src(nxt_src), .nxt_dst(nxt_dst),
    .nxt_ssub(nxt_ssub), .nxt_dsub(nxt_dsub), .adv_req(adv_req),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_ssub(cur_ssub), .cur_dsub(cur_dsub),
    .cur_pack(cur_pack), .cur_unpack(cur_unpack), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_cond(res_cond)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_state(input string tag);
    chk(cur_src == m_src, {tag, " src"}, 64'(cur_src), 64'(m_src));
    chk(cur_dst == m_dst, {tag, " dst"}, 64'(cur_dst), 64'(m_dst));
    chk(cur_ssub == m_ssub, {tag, " ssub"}, 64'(cur_ssub), 64'(m_ssub));
    chk(cur_dsub == m_dsub, {tag, " dsub"}, 64'(cur_dsub), 64'(m_dsub));
    chk({cur_unpack, cur_pack} == {m_unpack, m_pack}, {tag, " flags"},
        64'({cur_unpack, cur_pack}), 64'({m_unpack, m_pack}));
  endtask

  // one clock: entered just after a falling edge with inputs applied
  task automatic cycle(output bit accepted);
    bit rdy_exp, acc, at_end;
    logic [6:0] vlm1;
    if (rand_rdy) res_ready = ($urandom % 10) < 6;
    #1;
    rdy_exp = !m_ov || res_ready;
    acc = op_valid && rdy_exp;
    chk(op_ready == rdy_exp, "R10 op_ready", 64'(op_ready), 64'(rdy_exp));
    chk(adv_req == (acc && op_sel == 0 && op_step), op_step ? "R6 adv_req" : "R7 adv_req",
        64'(adv_req), 64'(acc && op_sel == 0 && op_step));
    if (acc) begin
      // result from state before the operation
      if (op_sel >= 1 && op_sel <= 4) begin
        m_res = 64'(shape_off[(int'(op_sel) - 1)*SHP_W +: SHP_W]); m_tag = "R4";
      end else if (op_sel == 5) begin m_res = 64'(m_src);  m_tag = "R5"; end
      else if (op_sel == 6) begin m_res = 64'(m_dst);  m_tag = "R5"; end
      else if (op_sel == 7) begin m_res = 64'(m_ssub); m_tag = "R5"; end
      else if (op_sel == 8) begin m_res = 64'(m_dsub); m_tag = "R5"; end
      else if (op_sel >= 9 && op_sel <= 11) begin m_res = '0; m_tag = "R8"; end
      else if (op_sel == 0) begin m_res = '0; m_tag = op_step ? "R6" : "R7"; end
      // state update
      if (op_step && op_sel == 0) begin
        m_src = nxt_src; m_dst = nxt_dst; m_ssub = nxt_ssub; m_dsub = nxt_dsub;
      end
      if (op_sel >= 12) begin
        if (op_step) begin m_pack = op_sel[0]; m_unpack = op_sel[1]; end
        m_res = 64'({m_unpack, m_pack});
        m_tag = op_step ? "R2" : "R3";
      end
      vlm1 = cfg_vl - 7'd1;
      at_end = (m_src == vlm1 && m_ssub == cfg_subvl) || (m_dst == vlm1 && m_dsub == cfg_subvl);
      m_cond = op_rec ? {2'b00, at_end, 1'b0} : 4'b0000;
      m_ov = 1;
    end else if (m_ov && res_ready) begin
      m_ov = 0;
    end
    @(posedge clk);
    #1;
    chk(res_valid == m_ov, "R11 res_valid", 64'(res_valid), 64'(m_ov));
    if (m_ov) begin
      chk(res_data == m_res, {m_tag, " res_data"}, res_data, m_res);
      chk(res_cond == m_cond, "R9 res_cond", 64'(res_cond), 64'(m_cond));
    end
    cmp_state(acc ? m_tag : "R10 idle");
    @(negedge clk);
    accepted = acc;
  endtask

  task automatic do_op(input logic [3:0] s, input bit st, input bit rc);
    bit a;
    op_sel = s; op_step = st; op_rec = rc; op_valid = 1;
    for (int n = 0; n < 200; n++) begin
      cycle(a);
      if (a) break;
    end
    op_valid = 0;
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) cycle(a);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    shape_off = {16'hD00D, 16'h0123, 16'h7FFF, 16'h0042};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(res_valid == 0, "R1 res_valid", 64'(res_valid), 0);
    cmp_state("R1 reset");
    @(negedge clk);

    // R2: each flag encoding
    do_op(4'd13, 1, 0); do_op(4'd14, 1, 0); do_op(4'd15, 1, 0); do_op(4'd12, 1, 0);
    do_op(4'd13, 1, 0);
    // R3: gated flag write keeps pack only
    do_op(4'd14, 0, 0); do_op(4'd15, 0, 1);
    // R4: every shape
    for (int k = 1; k <= 4; k++) do_op(4'(k), 0, 0);
    // R6: advance onto the last element, with record (R9 EQ set)
    nxt_src = 7'd3; nxt_dst = 7'd1; nxt_ssub = 2'd1; nxt_dsub = 2'd0;
    do_op(4'd0, 1, 1);
    // R5: all field reads
    for (int k = 5; k <= 8; k++) do_op(4'(k), 0, 1);
    // R7: no-op and inquiry with different iterator inputs
    nxt_src = 7'd0; nxt_dst = 7'd2; nxt_ssub = 2'd0; nxt_dsub = 2'd1;
    do_op(4'd0, 0, 0); do_op(4'd0, 0, 1);
    // R8: reserved selectors with step enabled
    for (int k = 9; k <= 11; k++) do_op(4'(k), 1, 1);
    // R9: destination side end with source not at end
    nxt_src = 7'd0; nxt_dst = 7'd3; nxt_ssub = 2'd0; nxt_dsub = 2'd1;
    do_op(4'd0, 1, 1);
    do_op(4'd0, 1, 0);

    // R10: back-pressure with pending offers
    res_ready = 0;
    do_op(4'd5, 0, 0);
    op_sel = 4'd6; op_valid = 1; idle(3);
    res_ready = 1; do_op(4'd6, 0, 0);

    // mixed random traffic against the model
    rand_rdy = 1;
    for (int i = 0; i < 600; i++) begin
      cfg_vl = 7'(1 + $urandom % 6);
      cfg_subvl = 2'($urandom % 4);
      nxt_src = 7'($urandom % cfg_vl);
      nxt_dst = 7'($urandom % cfg_vl);
      nxt_ssub = 2'($urandom % 4);
      nxt_dsub = 2'($urandom % 4);
      if ((i % 16) == 0) shape_off = {16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom)};
      do_op(4'($urandom % 16), 1'($urandom % 2), 1'($urandom % 2));
      if ((i % 7) == 0) idle(1);
    end
    rand_rdy = 0; res_ready = 1;
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule